// File: doc/BRIEF.md
# Bit-Band Alias Access Translator

This block sits between a single bus master and a word-wide memory port. Two 32 MB alias windows each map onto a 1 MB backing region. Every 32-bit word in an alias window stands for one bit of the backing region. A master access that falls in an alias window becomes an operation on that one bit. An alias read returns the bit in bit 0 of the read data. An alias write performs a locked read-modify-write that sets or clears the bit.

Accesses outside both windows go to the memory port unchanged, as a single transfer. The master holds its request until a one-cycle `ready_o` pulse. `busy_o` marks the whole time a request is in flight. The memory side uses a request/ready handshake. It also has a lock output, so that an arbiter can keep other masters off the memory during the read-modify-write pair.

Top module: `bitband_xlate`

## Requirements
- R1: An address outside both alias windows produces exactly one memory transfer. That transfer carries the master's address, write flag, write data and byte strobes unchanged, with `mem_lock_o` low. A read returns the memory word unchanged.
- R2: An alias read issues exactly one memory read, with `mem_lock_o` high. Its address is the word-aligned address of the target byte.
- R3: The read data of an alias read is the target bit in bit 0. Bits 31:1 are zero.
- R4: An alias write issues a read and then a write to the same word. The write's byte strobe is one-hot on the target byte lane: lane k is strobe bit k, and bits 7:0 of the word are lane 0. The target bit becomes bit 0 of the master's write data. All other bits keep their old value, and bits 31:1 of the write data have no effect.
- R5: During an alias write, `mem_lock_o` is high from the read request until the write completes. It does not drop between the two transfers.
- R6: Address mapping: the byte offset is address bits 24:2 shifted right by 3, which is bits 24:5. The bit number is bits 4:2. The bit's position in the memory word is lane×8 + bit number, where the lane is the byte offset modulo 4. The window at 0x22000000 maps to the region at 0x20000000. The window at 0x42000000 maps to the region at 0x40000000.
- R7: An alias read performs no memory write.
- R8: After reset, `busy_o`, `ready_o`, `mem_req_o` and `mem_lock_o` are low. `ready_o` is a single-cycle pulse. `busy_o` is high from acceptance until that pulse.
- R9: While `mem_req_o` is high and `mem_ready_i` is low, every memory-side output holds its value. The operation still completes correctly under memory wait states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Master request, held until ready_o |
| we_i | input | 1 | Master write flag |
| addr_i | input | 32 | Master byte address |
| wdata_i | input | 32 | Master write data |
| be_i | input | 4 | Master byte strobes |
| ready_o | output | 1 | Completion pulse |
| rdata_o | output | 32 | Read data, valid with ready_o |
| busy_o | output | 1 | Request in flight |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write flag |
| mem_addr_o | output | 32 | Memory word address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_be_o | output | 4 | Memory byte strobes |
| mem_lock_o | output | 1 | Keeps the memory for this master |
| mem_ready_i | input | 1 | Memory transfer completes |
| mem_rdata_i | input | 32 | Memory read data |

## Verification
The read half and the write half of an alias write can share one clock edge. The read completes, its data is merged, and the write is launched on that same edge. This is where a gap in the lock or a stale merge word would appear. The bench provokes the case with a zero-wait memory, so the read completes in its first cycle, and again with three wait states. Each time it judges the outcome from the logged transfers, a lock-fall monitor that runs every cycle, and the word left in memory.

// File: rtl/bb_pkg.sv
package bb_pkg;
  localparam int unsigned BYTE_BIT_W = 3;  // bit number inside a byte
  localparam int unsigned ALIAS_LSB  = 2;  // alias words are 4 bytes apart

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PASS,
    ST_RD,
    ST_WR,
    ST_RESP
  } bb_state_e;
endpackage

// File: rtl/bb_decode.sv
module bb_decode
  import bb_pkg::*;
#(
  parameter int unsigned AW          = 32,
  parameter int unsigned DW          = 32,
  parameter int unsigned NUM_REGIONS = 2,
  parameter int unsigned SPAN_W      = 25,
  parameter logic [NUM_REGIONS*AW-1:0] ALIAS_BASE  = {32'h4200_0000, 32'h2200_0000},
  parameter logic [NUM_REGIONS*AW-1:0] REGION_BASE = {32'h4000_0000, 32'h2000_0000},
  localparam int unsigned LANE_W = $clog2(DW/8),
  localparam int unsigned BSEL_W = LANE_W + BYTE_BIT_W,
  localparam int unsigned OFF_LSB = ALIAS_LSB + BYTE_BIT_W
) (
  input  logic [AW-1:ALIAS_LSB] addr_i,
  output logic                  hit_o,
  output logic [AW-1:0]         word_addr_o,
  output logic [BSEL_W-1:0]     bit_pos_o
);
  logic [NUM_REGIONS-1:0] hit_v;
  logic [AW-1:0]          byte_a [NUM_REGIONS];
  logic [AW-1:0]          sel_byte;

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
    assign hit_v[r]  = addr_i[AW-1:SPAN_W] == ALIAS_BASE[r*AW+SPAN_W +: AW-SPAN_W];
    assign byte_a[r] = REGION_BASE[r*AW +: AW] | AW'(addr_i[SPAN_W-1:OFF_LSB]);
  end

  // lowest region index wins on overlap
  always_comb begin
    hit_o    = 1'b0;
    sel_byte = '0;
    for (int r = NUM_REGIONS - 1; r >= 0; r--) begin
      if (hit_v[r]) begin
        hit_o    = 1'b1;
        sel_byte = byte_a[r];
      end
    end
  end

  assign word_addr_o = {sel_byte[AW-1:LANE_W], {LANE_W{1'b0}}};
  assign bit_pos_o   = {sel_byte[LANE_W-1:0], addr_i[OFF_LSB-1:ALIAS_LSB]};
endmodule

// File: rtl/bb_bitmod.sv
module bb_bitmod
  import bb_pkg::*;
#(
  parameter int unsigned DW = 32,
  localparam int unsigned LANE_W = $clog2(DW/8),
  localparam int unsigned BSEL_W = LANE_W + BYTE_BIT_W
) (
  input  logic [DW-1:0]     word_i,
  input  logic [BSEL_W-1:0] bit_pos_i,
  input  logic              set_i,
  output logic [DW-1:0]     word_o,
  output logic [DW/8-1:0]   lane_be_o,
  output logic              bit_o
);
  always_comb begin
    word_o            = word_i;
    word_o[bit_pos_i] = set_i;
  end

  assign lane_be_o = (DW/8)'(1) << bit_pos_i[BSEL_W-1:BYTE_BIT_W];
  assign bit_o     = word_i[bit_pos_i];
endmodule

// File: rtl/bb_seq.sv
module bb_seq
  import bb_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      accept_i,
  input  logic      alias_i,
  input  logic      op_we_i,
  input  logic      mem_done_i,
  output bb_state_e state_o
);
  bb_state_e state_d;

  always_comb begin
    state_d = state_o;
    unique case (state_o)
      ST_IDLE: if (accept_i)   state_d = alias_i ? ST_RD : ST_PASS;
      ST_PASS: if (mem_done_i) state_d = ST_RESP;
      ST_RD:   if (mem_done_i) state_d = op_we_i ? ST_WR : ST_RESP;
      ST_WR:   if (mem_done_i) state_d = ST_RESP;
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_o <= ST_IDLE;
    else         state_o <= state_d;
  end
endmodule

// File: rtl/bitband_xlate.sv
module bitband_xlate
  import bb_pkg::*;
#(
  parameter int unsigned AW          = 32,
  parameter int unsigned DW          = 32,
  parameter int unsigned NUM_REGIONS = 2,
  parameter int unsigned SPAN_W      = 25,
  parameter logic [NUM_REGIONS*AW-1:0] ALIAS_BASE  = {32'h4200_0000, 32'h2200_0000},
  parameter logic [NUM_REGIONS*AW-1:0] REGION_BASE = {32'h4000_0000, 32'h2000_0000},
  localparam int unsigned BEW    = DW / 8,
  localparam int unsigned BSEL_W = $clog2(BEW) + BYTE_BIT_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_i,
  input  logic           we_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic [BEW-1:0] be_i,
  output logic           ready_o,
  output logic [DW-1:0]  rdata_o,
  output logic           busy_o,
  output logic           mem_req_o,
  output logic           mem_we_o,
  output logic [AW-1:0]  mem_addr_o,
  output logic [DW-1:0]  mem_wdata_o,
  output logic [BEW-1:0] mem_be_o,
  output logic           mem_lock_o,
  input  logic           mem_ready_i,
  input  logic [DW-1:0]  mem_rdata_i
);
  bb_state_e state;
  logic accept, mem_done;

  logic              dec_hit;
  logic [AW-1:0]     dec_word;
  logic [BSEL_W-1:0] dec_bit;

  logic              q_we, q_alias;
  logic [AW-1:0]     q_addr, q_tgt;
  logic [DW-1:0]     q_wdata, q_old, q_rdata;
  logic [BEW-1:0]    q_be;
  logic [BSEL_W-1:0] q_bit;

  logic [DW-1:0]  mod_in, mod_word;
  logic [BEW-1:0] mod_be;
  logic           mod_bit;

  assign accept   = (state == ST_IDLE) && req_i;
  assign mem_done = mem_req_o && mem_ready_i;

  bb_decode #(
    .AW(AW), .DW(DW), .NUM_REGIONS(NUM_REGIONS), .SPAN_W(SPAN_W),
    .ALIAS_BASE(ALIAS_BASE), .REGION_BASE(REGION_BASE)
  ) u_decode (
    .addr_i      (addr_i[AW-1:ALIAS_LSB]),
    .hit_o       (dec_hit),
    .word_addr_o (dec_word),
    .bit_pos_o   (dec_bit)
  );

  bb_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .alias_i    (dec_hit),
    .op_we_i    (q_we),
    .mem_done_i (mem_done),
    .state_o    (state)
  );

  // read phase inspects live data, write phase merges into the held word
  assign mod_in = (state == ST_RD) ? mem_rdata_i : q_old;

  bb_bitmod #(.DW(DW)) u_bitmod (
    .word_i    (mod_in),
    .bit_pos_i (q_bit),
    .set_i     (q_wdata[0]),
    .word_o    (mod_word),
    .lane_be_o (mod_be),
    .bit_o     (mod_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_we    <= 1'b0;
      q_alias <= 1'b0;
      q_addr  <= '0;
      q_tgt   <= '0;
      q_wdata <= '0;
      q_be    <= '0;
      q_bit   <= '0;
      q_old   <= '0;
      q_rdata <= '0;
    end else begin
      if (accept) begin
        q_we    <= we_i;
        q_alias <= dec_hit;
        q_addr  <= addr_i;
        q_tgt   <= dec_word;
        q_wdata <= wdata_i;
        q_be    <= be_i;
        q_bit   <= dec_bit;
      end
      if (mem_done && state == ST_PASS) q_rdata <= mem_rdata_i;
      if (mem_done && state == ST_RD) begin
        q_old   <= mem_rdata_i;
        q_rdata <= {{(DW-1){1'b0}}, mod_bit};
      end
    end
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_lock_o  = 1'b0;
    mem_addr_o  = q_tgt;
    mem_wdata_o = '0;
    mem_be_o    = '1;
    unique case (state)
      ST_PASS: begin
        mem_req_o   = 1'b1;
        mem_we_o    = q_we;
        mem_addr_o  = q_addr;
        mem_wdata_o = q_wdata;
        mem_be_o    = q_be;
      end
      ST_RD: begin
        mem_req_o  = 1'b1;
        mem_lock_o = q_alias;
      end
      ST_WR: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_lock_o  = 1'b1;
        mem_wdata_o = mod_word;
        mem_be_o    = mod_be;
      end
      default: ;
    endcase
  end

  assign ready_o = (state == ST_RESP);
  assign busy_o  = (state != ST_IDLE);
  assign rdata_o = q_rdata;
endmodule

// File: rtl/bitband_xlate_chk.sv
module bitband_xlate_chk #(
  parameter int unsigned AW          = 32,
  parameter int unsigned DW          = 32,
  parameter int unsigned NUM_REGIONS = 2,
  parameter int unsigned SPAN_W      = 25,
  parameter logic [NUM_REGIONS*AW-1:0] ALIAS_BASE = {32'h4200_0000, 32'h2200_0000}
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                we_i,
  input logic [AW-1:SPAN_W]  tag_i,
  input logic                ready_o,
  input logic [DW-1:0]       rdata_o,
  input logic                busy_o,
  input logic                mem_req_o,
  input logic                mem_we_o,
  input logic [AW-1:0]       mem_addr_o,
  input logic [DW-1:0]       mem_wdata_o,
  input logic [DW/8-1:0]     mem_be_o,
  input logic                mem_lock_o,
  input logic                mem_ready_i
);
  logic in_window;
  always_comb begin
    in_window = 1'b0;
    for (int r = 0; r < NUM_REGIONS; r++)
      if (tag_i == ALIAS_BASE[r*AW+SPAN_W +: AW-SPAN_W]) in_window = 1'b1;
  end

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
      && $stable(mem_wdata_o) && $stable(mem_be_o) && $stable(mem_lock_o));

  p_lock_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_lock_o && mem_req_o && mem_ready_i && !mem_we_o |=> mem_lock_o || ready_o);

  p_lane_strobe_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && mem_lock_o |-> $countones(mem_be_o) == 1);

  p_ready_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);

  p_busy_ready_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> busy_o);

  p_idle_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o && !mem_lock_o);

  p_zero_ext_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && in_window && !we_i |-> rdata_o[DW-1:1] == '0);
endmodule

bind bitband_xlate bitband_xlate_chk #(
  .AW(AW), .DW(DW), .NUM_REGIONS(NUM_REGIONS), .SPAN_W(SPAN_W), .ALIAS_BASE(ALIAS_BASE)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .we_i        (we_i),
  .tag_i       (addr_i[AW-1:SPAN_W]),
  .ready_o     (ready_o),
  .rdata_o     (rdata_o),
  .busy_o      (busy_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_be_o    (mem_be_o),
  .mem_lock_o  (mem_lock_o),
  .mem_ready_i (mem_ready_i)
);

// File: tb/bitband_xlate_bench.sv
module bitband_xlate_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [31:0] addr = '0, wdata = '0;
  logic [3:0]  be = '0;
  logic        ready, busy;
  logic [31:0] rdata;
  logic        m_req, m_we, m_lock, m_ready;
  logic [31:0] m_addr, m_wdata, m_rdata;
  logic [3:0]  m_be;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitband_xlate u_bitband_xlate (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .be_i(be), .ready_o(ready), .rdata_o(rdata), .busy_o(busy),
    .mem_req_o(m_req), .mem_we_o(m_we), .mem_addr_o(m_addr), .mem_wdata_o(m_wdata),
    .mem_be_o(m_be), .mem_lock_o(m_lock), .mem_ready_i(m_ready), .mem_rdata_i(m_rdata)
  );

  // memory model, word-indexed by address bits 11:2
  logic [31:0] mem [1024];
  int waits = 0;
  int wcnt  = 0;
  assign m_ready = m_req && (wcnt >= waits);
  assign m_rdata = mem[m_addr[11:2]];

  // transfer log
  logic        tr_we   [8];
  logic [31:0] tr_addr [8];
  logic [3:0]  tr_be   [8];
  logic [31:0] tr_wd   [8];
  logic        tr_lock [8];
  int n_tr = 0;
  int lock_gaps = 0;
  logic lock_prev = 1'b0;

  always @(posedge clk) begin
    lock_prev <= m_lock;
    if (lock_prev && !m_lock && !ready) lock_gaps <= lock_gaps + 1;
    if (m_req) begin
      if (m_ready) begin
        wcnt <= 0;
        if (m_we)
          for (int b = 0; b < 4; b++)
            if (m_be[b]) mem[m_addr[11:2]][b*8 +: 8] <= m_wdata[b*8 +: 8];
        if (n_tr < 8) begin
          tr_we[n_tr]   <= m_we;
          tr_addr[n_tr] <= m_addr;
          tr_be[n_tr]   <= m_be;
          tr_wd[n_tr]   <= m_wdata;
          tr_lock[n_tr] <= m_lock;
        end
        n_tr <= n_tr + 1;
      end else begin
        wcnt <= wcnt + 1;
      end
    end
  end

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [31:0] a, input logic [31:0] d,
                        input logic [3:0] s, output logic [31:0] rd);
    @(negedge clk);
    n_tr = 0;
    req = 1'b1; we = w; addr = a; wdata = d; be = s;
    rd = 'x;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      check(busy, "R8 busy during request", {31'b0, busy}, 32'h1);
      if (ready) begin
        rd = rdata;
        break;
      end
    end
    req = 1'b0;
    @(negedge clk);
    check(!ready && !busy, "R8 single ready pulse", {30'b0, ready, busy}, 32'h0);
  endtask

  task automatic t_reset;
    check(!busy && !ready && !m_req && !m_lock, "R8 reset state",
          {28'b0, busy, ready, m_req, m_lock}, 32'h0);
  endtask

  task automatic t_pass;
    logic [31:0] r;
    access(1'b1, 32'h3000_0010, 32'hA5C3_7E19, 4'b0110, r);
    check(n_tr == 1, "R1 pass write count", n_tr, 1);
    check(tr_we[0] && tr_addr[0] == 32'h3000_0010 && tr_be[0] == 4'b0110 && tr_wd[0] == 32'hA5C3_7E19,
          "R1 pass write fields", tr_addr[0], 32'h3000_0010);
    check(!tr_lock[0], "R1 pass unlocked", {31'b0, tr_lock[0]}, 0);
    mem[10'h004] = 32'h1357_9BDF;
    access(1'b0, 32'h3000_0010, 32'h0, 4'hF, r);
    check(r == 32'h1357_9BDF, "R1 pass read data", r, 32'h1357_9BDF);
    check(n_tr == 1 && !tr_we[0], "R1 pass read single", n_tr, 1);
  endtask

  task automatic t_alias_read;
    logic [31:0] r;
    mem[10'h3FF] = 32'h8000_0000;
    access(1'b0, 32'h23FF_FFFC, 32'h0, 4'hF, r);
    check(r == 32'h1, "R3 R6 top bit of last byte", r, 32'h1);
    check(n_tr == 1 && !tr_we[0], "R7 alias read no write", n_tr, 1);
    check(tr_addr[0] == 32'h200F_FFFC && tr_lock[0], "R2 R6 alias read word addr",
          tr_addr[0], 32'h200F_FFFC);
    access(1'b0, 32'h23FF_FFF8, 32'h0, 4'hF, r);
    check(r == 32'h0, "R3 neighbour bit zero", r, 32'h0);
    mem[10'h3FF] = 32'hFFFF_FFFF;
    access(1'b0, 32'h23FF_FFE0, 32'h0, 4'hF, r);
    check(r == 32'h1, "R3 upper bits zeroed", r, 32'h1);
  endtask

  task automatic t_alias_write;
    logic [31:0] r;
    // byte 0x20000102 bit 5 -> word bit 21
    mem[10'h040] = 32'h0;
    access(1'b1, 32'h2200_2054, 32'hFFFF_FFFF, 4'h0, r);
    check(mem[10'h040] == 32'h0020_0000, "R4 R6 set bit", mem[10'h040], 32'h0020_0000);
    check(n_tr == 2 && !tr_we[0] && tr_we[1], "R4 read then write", n_tr, 2);
    check(tr_addr[1] == 32'h2000_0100 && tr_be[1] == 4'b0100, "R4 lane strobe",
          {tr_be[1], tr_addr[1][27:0]}, {4'b0100, 28'h000_0100});
    check(tr_lock[0] && tr_lock[1], "R5 both locked", {30'b0, tr_lock[0], tr_lock[1]}, 32'h3);
    // peripheral window, byte 0x40000041 bit 3 -> word bit 11, high write bits ignored
    mem[10'h010] = 32'hFFFF_FFFF;
    access(1'b1, 32'h4200_082C, 32'hFFFF_FFFE, 4'hF, r);
    check(mem[10'h010] == 32'hFFFF_F7FF, "R4 R6 clear bit periph", mem[10'h010], 32'hFFFF_F7FF);
    check(tr_addr[1] == 32'h4000_0040 && tr_be[1] == 4'b0010, "R6 periph target",
          tr_addr[1], 32'h4000_0040);
  endtask

  task automatic t_waits;
    logic [31:0] r;
    waits = 3;
    mem[10'h3FF] = 32'h0000_0000;
    access(1'b1, 32'h23FF_FF80, 32'h1, 4'hF, r);  // byte 0x200FFFFC bit 0
    check(mem[10'h3FF] == 32'h0000_0001, "R9 write under wait states", mem[10'h3FF], 32'h1);
    access(1'b0, 32'h23FF_FF80, 32'h0, 4'hF, r);
    check(r == 32'h1, "R9 read under wait states", r, 32'h1);
    waits = 0;
    access(1'b1, 32'h23FF_FF80, 32'h0, 4'hF, r);
    check(mem[10'h3FF] == 32'h0, "R4 back to back clear", mem[10'h3FF], 32'h0);
    check(lock_gaps == 0, "R5 lock never dropped mid operation", lock_gaps, 0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_pass();
    t_alias_read();
    t_alias_write();
    t_waits();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule